// File: doc/BRIEF.md
# Dual-Port Synchronous Byte-Lane RAM

This block is a true dual-port static RAM with two independent ports, left and right. Each port has its own clock, a 16-bit word address, an 18-bit write data bus and an 18-bit read data bus. Each word is split into two 9-bit lanes. A port acts on its rising clock edge. It can write either lane or both, and it can read either lane or both. The array depth is a parameter, and the array is indexed by the low address bits.

Each port chooses its own read latency with a static mode pin. In flow-through mode, read data follows the edge that sampled the address. In pipelined mode, read data comes one edge later. In pipelined mode the port-select and direction controls pass through two registers. The lane selects pass through only one register in both modes. As a result, a pipelined port keeps driving for one more cycle after it is deselected, and on that cycle the lanes it drives are chosen by the lane selects that are current at that point.

The tri-state bus of a physical part is modelled here as a data bus plus one output-enable bit per lane. The output-enable input acts without a clock.

Top module: `twin_port_lane_ram`

## Requirements
- R1: A port is selected only when `sel0_n` is 0 and `sel1` is 1. On a deselected edge nothing is written, and the read that edge would produce drives no lane.
- R2: The lower lane is data bits 8:0 and is gated by `lo_n`. The upper lane is bits 17:9 and is gated by `hi_n`. A selected edge with `rd_wr` = 0 writes `din` into each lane whose select is 0. The other lane, or both lanes when both selects are 1, keeps its stored value.
- R3: A selected edge with `rd_wr` = 1 is a read. Each lane whose select is 0 is driven with the stored value, where `drv[0]` enables the lower lane and `drv[1]` the upper lane. An unselected lane has its `drv` bit at 0.
- R4: While `oe_n` is 1, `drv` is 0 with no clock edge needed. When `oe_n` returns to 0, the clocked state is driven again.
- R5: With `pipe` = 0, the data and lane enables of a read sampled at edge k are present from edge k until edge k+1.
- R6: With `pipe` = 1, the data of a read sampled at edge k is present from edge k+1 until edge k+2.
- R7: With `pipe` = 1, the select and direction controls take two edges to act. A port deselected at edge k+1 still drives the read from edge k after edge k+1, and stops driving after edge k+2.
- R8: In both modes, the `drv` bits after edge k follow the lane selects sampled at edge k.
- R9: The ports run on unrelated clocks. A word written through one port is read back through the other port on a later read. Traffic to different addresses on both ports at once does not interfere.
- R10: `rst_n` = 0 clears every `drv` bit at once. Stored words survive a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset of both output stages |
| clk_l | input | 1 | Left port clock |
| sel0_n_l | input | 1 | Left select, active low |
| sel1_l | input | 1 | Left select, active high |
| rd_wr_l | input | 1 | Left direction: 1 read, 0 write |
| hi_n_l | input | 1 | Left upper-lane select, active low |
| lo_n_l | input | 1 | Left lower-lane select, active low |
| oe_n_l | input | 1 | Left output enable, active low, unclocked |
| pipe_l | input | 1 | Left latency mode: 1 pipelined, 0 flow-through |
| addr_l | input | 16 | Left word address |
| din_l | input | 18 | Left write data |
| dout_l | output | 18 | Left read data, valid in lanes with `drv_l` set |
| drv_l | output | 2 | Left per-lane output enable |
| clk_r | input | 1 | Right port clock |
| sel0_n_r | input | 1 | Right select, active low |
| sel1_r | input | 1 | Right select, active high |
| rd_wr_r | input | 1 | Right direction: 1 read, 0 write |
| hi_n_r | input | 1 | Right upper-lane select, active low |
| lo_n_r | input | 1 | Right lower-lane select, active low |
| oe_n_r | input | 1 | Right output enable, active low, unclocked |
| pipe_r | input | 1 | Right latency mode |
| addr_r | input | 16 | Right word address |
| din_r | input | 18 | Right write data |
| dout_r | output | 18 | Right read data |
| drv_r | output | 2 | Right per-lane output enable |

## Verification
The hardest case to reach is the pipelined deselect. It needs a read at one edge. At the next edge the port must be deselected while its lane selects are low, and the lane selects must differ from those of the read. Only then does the output show the held-over word in lanes that the read itself never asked for.

The stimulus builds this case on purpose in pipelined mode. It deselects once through each select input, and it alternates the lane-select patterns from edge to edge.

Cross-port visibility is reached in two ways. First, both ports write disjoint address ranges at the same time on clocks of different period. Then each port reads back the other port's range.

// File: rtl/lane_ram_pkg.sv
package lane_ram_pkg;
  localparam int LANE_W = 9;
  localparam int LANES  = 2;
  localparam int WORD_W = LANE_W * LANES;

  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [LANES-1:0]  lane_mask_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/lane_store.sv
// One 9-bit lane of the array. Each port owns a private bank and a tag
// bit per word. The XOR of the two tags names the port that wrote last,
// so each bank has a single writer clock.
module lane_store
  import lane_ram_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_a,
  input  logic             we_a,
  input  logic [IDX_W-1:0] idx_a,
  input  lane_t            wd_a,
  output lane_t            q_a,
  input  logic             clk_b,
  input  logic             we_b,
  input  logic [IDX_W-1:0] idx_b,
  input  lane_t            wd_b,
  output lane_t            q_b
);
  lane_t bank_a [DEPTH];
  lane_t bank_b [DEPTH];
  logic  tag_a  [DEPTH];
  logic  tag_b  [DEPTH];

  // tag_a == tag_b : port a wrote last; tags differ : port b wrote last
  always_ff @(posedge clk_a) begin
    if (we_a) begin
      bank_a[idx_a] <= wd_a;
      tag_a[idx_a]  <= tag_b[idx_a];
    end
    q_a <= (tag_a[idx_a] ^ tag_b[idx_a]) ? bank_b[idx_a] : bank_a[idx_a];
  end

  always_ff @(posedge clk_b) begin
    if (we_b) begin
      bank_b[idx_b] <= wd_b;
      tag_b[idx_b]  <= ~tag_a[idx_b];
    end
    q_b <= (tag_a[idx_b] ^ tag_b[idx_b]) ? bank_b[idx_b] : bank_a[idx_b];
  end
endmodule

// File: rtl/port_front.sv
// Per-port control: select decode, lane write mask, and the read output
// stage with a flow-through or pipelined tap.
module port_front
  import lane_ram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel0_n,
  input  logic       sel1,
  input  logic       rd_wr,
  input  lane_mask_t lane_n,
  input  logic       oe_n,
  input  logic       pipe,
  input  word_t      q_word,
  output lane_mask_t wr_lane,
  output word_t      dout,
  output lane_mask_t drv
);
  logic       chosen;
  logic       rd_req;
  lane_mask_t lane_pick;
  logic       rd_s1;     // select/direction, first register
  logic       rd_s2;     // select/direction, second register (pipelined)
  lane_mask_t lane_s1;   // lane selects, single register in both modes
  word_t      word_s2;   // extra data register for pipelined reads
  logic       rd_live;

  assign chosen    = ~sel0_n & sel1;
  assign rd_req    = chosen & rd_wr;
  assign lane_pick = ~lane_n;
  assign wr_lane   = (chosen && !rd_wr) ? lane_pick : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_s1   <= 1'b0;
      rd_s2   <= 1'b0;
      lane_s1 <= '0;
    end else begin
      rd_s1   <= rd_req;
      rd_s2   <= rd_s1;
      lane_s1 <= lane_pick;
    end
  end

  always_ff @(posedge clk) begin
    word_s2 <= q_word;
  end

  assign rd_live = pipe ? rd_s2 : rd_s1;
  assign dout    = pipe ? word_s2 : q_word;
  assign drv     = (rd_live && !oe_n) ? lane_s1 : '0;

  // flow-through output reflects a read sampled at the previous edge
  assert_flow_one_edge_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe && drv != '0) |-> $past(rd_req));

  // pipelined output reflects a read sampled two edges back
  assert_pipe_two_edges_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    (pipe && drv != '0) |-> $past(rd_req, 2));

  // a port deselected at the last edge may still drive only in pipelined mode (R7)
  assert_deselect_lag_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (drv != '0 && !$past(rd_req)) |-> pipe);

  // lanes driven are those whose select was low at the previous edge
  assert_lane_one_stage_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (drv != '0) |-> ((drv & $past(lane_n)) == '0));
endmodule

// File: rtl/twin_port_lane_ram.sv
module twin_port_lane_ram
  import lane_ram_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              rst_n,
  input  logic              clk_l,
  input  logic              sel0_n_l,
  input  logic              sel1_l,
  input  logic              rd_wr_l,
  input  logic              hi_n_l,
  input  logic              lo_n_l,
  input  logic              oe_n_l,
  input  logic              pipe_l,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [WORD_W-1:0] din_l,
  output logic [WORD_W-1:0] dout_l,
  output logic [LANES-1:0]  drv_l,
  input  logic              clk_r,
  input  logic              sel0_n_r,
  input  logic              sel1_r,
  input  logic              rd_wr_r,
  input  logic              hi_n_r,
  input  logic              lo_n_r,
  input  logic              oe_n_r,
  input  logic              pipe_r,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic [WORD_W-1:0] din_r,
  output logic [WORD_W-1:0] dout_r,
  output logic [LANES-1:0]  drv_r
);
  lane_mask_t wr_l, wr_r;
  word_t      qw_l, qw_r;

  generate
    if (ADDR_W > IDX_W) begin : g_hi
      logic unused_addr_hi;
      assign unused_addr_hi = ^{addr_l[ADDR_W-1:IDX_W], addr_r[ADDR_W-1:IDX_W]};
    end
  endgenerate

  port_front u_front_l (
    .clk(clk_l), .rst_n(rst_n), .sel0_n(sel0_n_l), .sel1(sel1_l),
    .rd_wr(rd_wr_l), .lane_n({hi_n_l, lo_n_l}), .oe_n(oe_n_l),
    .pipe(pipe_l), .q_word(qw_l), .wr_lane(wr_l), .dout(dout_l), .drv(drv_l)
  );

  port_front u_front_r (
    .clk(clk_r), .rst_n(rst_n), .sel0_n(sel0_n_r), .sel1(sel1_r),
    .rd_wr(rd_wr_r), .lane_n({hi_n_r, lo_n_r}), .oe_n(oe_n_r),
    .pipe(pipe_r), .q_word(qw_r), .wr_lane(wr_r), .dout(dout_r), .drv(drv_r)
  );

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      lane_store #(.DEPTH(DEPTH)) u_store (
        .clk_a(clk_l), .we_a(wr_l[i]), .idx_a(addr_l[IDX_W-1:0]),
        .wd_a(din_l[i*LANE_W +: LANE_W]), .q_a(qw_l[i*LANE_W +: LANE_W]),
        .clk_b(clk_r), .we_b(wr_r[i]), .idx_b(addr_r[IDX_W-1:0]),
        .wd_b(din_r[i*LANE_W +: LANE_W]), .q_b(qw_r[i*LANE_W +: LANE_W])
      );
    end
  endgenerate

  // output enable high silences each port regardless of clocked state
  assert_oe_silences_left_R4 : assert property (@(posedge clk_l) disable iff (!rst_n)
    oe_n_l |-> (drv_l == '0));
  assert_oe_silences_right_R4 : assert property (@(posedge clk_r) disable iff (!rst_n)
    oe_n_r |-> (drv_r == '0));
endmodule

// File: tb/sim_twin_port_lane_ram.sv
module sim_twin_port_lane_ram;
  localparam int CLK_PERIOD = 10;
  localparam int R_PERIOD   = 14;
  localparam int DEPTH      = 256;

  logic        rst_n;
  logic        clk_l = 0, clk_r = 0;
  logic        sel0_n_l, sel1_l, rd_wr_l, hi_n_l, lo_n_l, oe_n_l, pipe_l;
  logic        sel0_n_r, sel1_r, rd_wr_r, hi_n_r, lo_n_r, oe_n_r, pipe_r;
  logic [15:0] addr_l, addr_r;
  logic [17:0] din_l, din_r, dout_l, dout_r;
  logic [1:0]  drv_l, drv_r;

  int total = 0;
  int bad   = 0;
  bit chk_on = 0;
  bit done   = 0;
  string tag_l = "R10";
  string tag_r = "R10";

  // reference model state
  logic [17:0] mem_m [DEPTH];
  logic        en_f [2], en_p [2], rd_prev [2];
  logic [1:0]  bs_m [2];
  logic [17:0] dat_f [2], dat_p [2], dat_prev [2];

  twin_port_lane_ram u0 (
    .rst_n(rst_n),
    .clk_l(clk_l), .sel0_n_l(sel0_n_l), .sel1_l(sel1_l), .rd_wr_l(rd_wr_l),
    .hi_n_l(hi_n_l), .lo_n_l(lo_n_l), .oe_n_l(oe_n_l), .pipe_l(pipe_l),
    .addr_l(addr_l), .din_l(din_l), .dout_l(dout_l), .drv_l(drv_l),
    .clk_r(clk_r), .sel0_n_r(sel0_n_r), .sel1_r(sel1_r), .rd_wr_r(rd_wr_r),
    .hi_n_r(hi_n_r), .lo_n_r(lo_n_r), .oe_n_r(oe_n_r), .pipe_r(pipe_r),
    .addr_r(addr_r), .din_r(din_r), .dout_r(dout_r), .drv_r(drv_r)
  );

  always #(CLK_PERIOD/2) clk_l = ~clk_l;
  always #(R_PERIOD/2)   clk_r = ~clk_r;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_step(input int p, input logic s0n, input logic s1,
                            input logic rw, input logic [1:0] lsn,
                            input logic [15:0] a, input logic [17:0] d);
    logic rd;
    logic [17:0] cur;
    if (!rst_n) begin
      en_f[p] = 0; en_p[p] = 0; rd_prev[p] = 0; bs_m[p] = 2'b00;
      return;
    end
    rd  = !s0n && s1 && rw;
    cur = mem_m[a[7:0]];
    en_p[p]     = rd_prev[p];
    dat_p[p]    = dat_prev[p];
    en_f[p]     = rd;
    dat_f[p]    = cur;
    bs_m[p]     = ~lsn;
    rd_prev[p]  = rd;
    dat_prev[p] = cur;
    if (!s0n && s1 && !rw) begin
      if (!lsn[0]) mem_m[a[7:0]][8:0]  = d[8:0];
      if (!lsn[1]) mem_m[a[7:0]][17:9] = d[17:9];
    end
  endtask

  always @(posedge clk_l)
    model_step(0, sel0_n_l, sel1_l, rd_wr_l, {hi_n_l, lo_n_l}, addr_l, din_l);
  always @(posedge clk_r)
    model_step(1, sel0_n_r, sel1_r, rd_wr_r, {hi_n_r, lo_n_r}, addr_r, din_r);

  task automatic check_port(input int p, input string tag, input logic pm,
                            input logic oen, input logic [1:0] dv,
                            input logic [17:0] dq);
    logic [1:0]  ed;
    logic [17:0] ew;
    ed = ((pm ? en_p[p] : en_f[p]) && !oen) ? bs_m[p] : 2'b00;
    ew = pm ? dat_p[p] : dat_f[p];
    chk(dv == ed, tag, p == 0 ? "drv_l" : "drv_r", 32'(dv), 32'(ed));
    if (ed[0] && dv[0]) chk(dq[8:0] == ew[8:0], tag, "lower lane", 32'(dq[8:0]), 32'(ew[8:0]));
    if (ed[1] && dv[1]) chk(dq[17:9] == ew[17:9], tag, "upper lane", 32'(dq[17:9]), 32'(ew[17:9]));
  endtask

  always @(negedge clk_l) if (chk_on) check_port(0, tag_l, pipe_l, oe_n_l, drv_l, dout_l);
  always @(negedge clk_r) if (chk_on) check_port(1, tag_r, pipe_r, oe_n_r, drv_r, dout_r);

  task automatic op_l(input logic s0n, input logic s1, input logic rw,
                      input logic [1:0] lsn, input int a, input logic [17:0] d);
    @(negedge clk_l); #1;
    sel0_n_l = s0n; sel1_l = s1; rd_wr_l = rw; {hi_n_l, lo_n_l} = lsn;
    addr_l = 16'(a); din_l = d;
  endtask

  task automatic op_r(input logic s0n, input logic s1, input logic rw,
                      input logic [1:0] lsn, input int a, input logic [17:0] d);
    @(negedge clk_r); #1;
    sel0_n_r = s0n; sel1_r = s1; rd_wr_r = rw; {hi_n_r, lo_n_r} = lsn;
    addr_r = 16'(a); din_r = d;
  endtask

  function automatic logic [17:0] pat(input int a, input int salt);
    return {9'(a * 3 + 1 + salt), 9'(~(a + salt))};
  endfunction

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog run did not complete");
      finish_run();
    end
  end

  initial begin
    rst_n = 0;
    {sel0_n_l, sel1_l, rd_wr_l, hi_n_l, lo_n_l, oe_n_l, pipe_l} = 7'b1011100;
    {sel0_n_r, sel1_r, rd_wr_r, hi_n_r, lo_n_r, oe_n_r, pipe_r} = 7'b1011100;
    addr_l = 0; addr_r = 0; din_l = 0; din_r = 0;
    for (int i = 0; i < DEPTH; i++) mem_m[i] = 'x;
    repeat (3) @(negedge clk_r);
    chk(drv_l == 2'b00, "R10", "drv_l in reset", 32'(drv_l), 0);
    chk(drv_r == 2'b00, "R10", "drv_r in reset", 32'(drv_r), 0);
    #1 rst_n = 1;
    chk_on = 1;

    // fill the whole array from the left port, flow-through
    tag_l = "R2";
    for (int a = 0; a < DEPTH; a++) op_l(0, 1, 0, 2'b00, a, pat(a, 0));

    // flow-through reads across all lane-select patterns
    tag_l = "R5";
    for (int a = 0; a < 16; a++) op_l(0, 1, 1, 2'(a), a, 0);
    tag_l = "R3";
    for (int a = 16; a < 24; a++) op_l(0, 1, 1, 2'(a + 1), a, 0);

    // single-lane writes leave the other lane untouched
    tag_l = "R2";
    op_l(0, 1, 0, 2'b10, 5, 18'h3FFFF);
    op_l(0, 1, 0, 2'b01, 6, 18'h00000);
    op_l(0, 1, 0, 2'b11, 9, 18'h15555);
    op_l(0, 1, 1, 2'b00, 5, 0);
    op_l(0, 1, 1, 2'b00, 6, 0);
    op_l(0, 1, 1, 2'b00, 9, 0);

    // deselected edges: writes ignored, reads drive nothing
    tag_l = "R1";
    op_l(1, 1, 0, 2'b00, 7, 18'h2AAAA);
    op_l(0, 0, 0, 2'b00, 8, 18'h12345);
    op_l(1, 0, 0, 2'b00, 10, 18'h0F0F0);
    op_l(1, 1, 1, 2'b00, 7, 0);
    op_l(0, 0, 1, 2'b00, 8, 0);
    op_l(0, 1, 1, 2'b00, 7, 0);
    op_l(0, 1, 1, 2'b00, 8, 0);
    op_l(0, 1, 1, 2'b00, 10, 0);

    // output enable high silences reads; low again restores
    tag_l = "R4";
    op_l(0, 1, 1, 2'b00, 11, 0);
    @(posedge clk_l); #2 oe_n_l = 1;
    op_l(0, 1, 1, 2'b00, 12, 0);
    op_l(0, 1, 1, 2'b01, 13, 0);
    @(negedge clk_l); #1 oe_n_l = 0;
    op_l(0, 1, 1, 2'b00, 14, 0);

    // pipelined reads, deselect lag and lane-select timing
    op_l(1, 0, 1, 2'b11, 0, 0);
    @(negedge clk_l); #1 pipe_l = 1;
    op_l(1, 0, 1, 2'b11, 0, 0);
    tag_l = "R6";
    for (int a = 20; a < 28; a++) op_l(0, 1, 1, 2'(a), a, 0);
    tag_l = "R7";
    op_l(0, 1, 1, 2'b11, 30, 0);
    op_l(0, 0, 1, 2'b00, 31, 0);
    op_l(0, 0, 1, 2'b00, 32, 0);
    op_l(0, 1, 1, 2'b00, 33, 0);
    op_l(1, 1, 1, 2'b10, 34, 0);
    op_l(1, 1, 1, 2'b01, 35, 0);
    tag_l = "R8";
    op_l(0, 1, 1, 2'b00, 40, 0);
    op_l(0, 1, 1, 2'b11, 41, 0);
    op_l(0, 1, 1, 2'b01, 42, 0);
    op_l(0, 1, 1, 2'b10, 43, 0);
    op_l(1, 1, 1, 2'b00, 44, 0);
    op_l(1, 1, 1, 2'b11, 44, 0);

    // right port reads what the left port wrote
    tag_r = "R9";
    pipe_r = 1;
    for (int a = 3; a < 12; a++) op_r(0, 1, 1, 2'b00, a, 0);
    op_r(1, 0, 1, 2'b11, 0, 0);

    // concurrent writes to disjoint ranges on unrelated clocks
    tag_l = "R9";
    @(negedge clk_l); #1 pipe_l = 0;
    fork
      begin
        for (int a = 0; a < 32; a++) op_l(0, 1, 0, 2'b00, a, pat(a, 77));
        for (int a = 60; a < 70; a++) op_l(0, 1, 1, 2'b00, a, 0);
        op_l(1, 0, 1, 2'b11, 0, 0);
      end
      begin
        for (int a = 128; a < 160; a++) op_r(0, 1, 0, 2'(a), a, pat(a, 201));
        for (int a = 200; a < 210; a++) op_r(0, 1, 1, 2'b00, a, 0);
        op_r(1, 0, 1, 2'b11, 0, 0);
      end
    join
    fork
      for (int a = 128; a < 160; a++) op_l(0, 1, 1, 2'b00, a, 0);
      for (int a = 0; a < 32; a++) op_r(0, 1, 1, 2'b00, a, 0);
    join
    op_l(1, 0, 1, 2'b11, 0, 0);
    op_r(1, 0, 1, 2'b11, 0, 0);

    // reset mid-run: outputs cleared, contents kept
    tag_l = "R10"; tag_r = "R10";
    op_l(0, 1, 1, 2'b00, 3, 0);
    op_r(0, 1, 1, 2'b00, 4, 0);
    @(negedge clk_l); #1 rst_n = 0;
    #2;
    chk(drv_l == 2'b00, "R10", "drv_l after reset", 32'(drv_l), 0);
    chk(drv_r == 2'b00, "R10", "drv_r after reset", 32'(drv_r), 0);
    repeat (2) @(negedge clk_r);
    #1 rst_n = 1;
    op_l(0, 1, 1, 2'b00, 3, 0);
    op_r(0, 1, 1, 2'b00, 130, 0);
    repeat (4) op_l(1, 0, 1, 2'b11, 0, 0);
    repeat (4) op_r(1, 0, 1, 2'b11, 0, 0);

    done = 1;
    finish_run();
  end
endmodule